// File: doc/BRIEF.md
# Command Packet Decoder

This block sits behind a command FIFO and interprets the stream of 32-bit words that software queues there. Each packet opens with a header word whose low three bits give the packet type. Depending on the type, the header sets up one of several actions. It can do nothing, or it can redirect the FIFO read pointer. It can drive a burst of register writes to consecutive or repeated addresses. It can drive a sparse set of register writes chosen by a bitmask. It can also drive a run of memory writes into the frame buffer or texture memory. Data words that follow the header feed those writes one at a time.

Headers the block cannot handle raise a one-cycle error pulse, and the next word is taken as a fresh header. Words arrive over a valid/ready stream. Register writes and memory writes each leave through their own registered valid/ready port. The input is held off whenever the port a word is bound for cannot take a new transaction, so backpressure never drops a word. Jumps, errors and byte-disable warnings are single-cycle pulses.

Top module: `cmd_packet_decoder`

## Requirements
- R1: The packet type is header bits [2:0]; a type 0 header whose code field (bits [5:3]) is 0 is a no-op: it produces no write, jump or error, and the next word is a header.
- R2: A type 0 header with code 3 pulses `jump_valid` for one cycle, in the cycle after the header is accepted, with `jump_addr` = (header >> 4) AND 0xFFFFFC.
- R3: A type 1 header starts a burst of N register writes, where N is bits [31:16] and the first address is bits [14:3]; when bit 15 is 1 the address rises by one after each data word, otherwise every write goes to the same address.
- R4: A type 1 header with a count of zero produces no register write, and the next word is treated as a header.
- R5: A type 2 header treats bits [31:3] as a mask tested from bit 3 upward; mask bit i set consumes one data word and writes it to register SPARSE_BASE + i (default 0x0B0), and a clear bit consumes no word.
- R6: A type 4 header writes one data word per set bit i of mask bits [28:15] to register (bits [14:3]) + i, lowest bit first; after the masked words, it reads and discards the number of words given by bits [31:29], with no write for them.
- R7: A type 5 header with bits [31:30] = 2 (frame buffer, `mem_wr_tex` = 0) or 3 (texture, `mem_wr_tex` = 1) reads one address word. The start word address is that word's bits [23:0] shifted right by 2. Then follow as many data words as bits [21:3] give, written to ascending addresses. With a count of zero, only the address word is read.
- R8: A type 5 header with any of bits [29:22] set pulses `warn_bytedis` for one cycle after the header is accepted; with those bits clear it does not pulse.
- R9: Type 3, 6 and 7 headers, type 0 codes other than 0 and 3, and type 5 headers whose bits [31:30] are 0 or 1 pulse `err_unsup` for one cycle after the header. They consume no further word, and the next word is a header.
- R10: While a transaction waits on its port with ready low, its valid and payload stay unchanged. No word bound for that port is accepted, and every data word yields exactly one transaction, in order.
- R11: In the cycle after reset, neither write port is valid, no pulse is active and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word available |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Decoder accepts the word this cycle |
| reg_wr_valid | output | 1 | Register write pending |
| reg_wr_ready | input | 1 | Register write taken |
| reg_wr_addr | output | 12 | Register number |
| reg_wr_data | output | 32 | Register data |
| mem_wr_valid | output | 1 | Memory write pending |
| mem_wr_ready | input | 1 | Memory write taken |
| mem_wr_tex | output | 1 | 0 frame buffer, 1 texture memory |
| mem_wr_addr | output | 22 | Word address |
| mem_wr_data | output | 32 | Memory data |
| jump_valid | output | 1 | Read-pointer load pulse |
| jump_addr | output | 24 | New read pointer |
| err_unsup | output | 1 | Unsupported header pulse |
| warn_bytedis | output | 1 | Byte-disable warning pulse |

## Verification
Every result is due one cycle after the word that causes it is accepted. A register or memory write becomes valid on the next cycle, and so do the jump, error and warning pulses that follow a header. The driving task returns at the falling edge after the accepting rising edge, and the pulse checks sample right there. Write transactions are gathered by a falling-edge monitor that logs only cycles where valid and ready are both high, so each logged write is the one handed over at the next rising edge, however long backpressure held it.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int WORD_W  = 32;
  localparam int REG_AW  = 12;
  localparam int MEM_AW  = 22;
  localparam int JUMP_W  = 24;
  localparam int BCNT_W  = 16;
  localparam int MCNT_W  = 19;
  localparam int SMASK_W = 29;
  localparam int XMASK_W = 14;
  localparam int PAD_W   = 3;
  localparam int BD_W    = 8;
  localparam int SIDX_W  = $clog2(SMASK_W);

  typedef enum logic [2:0] {
    K_NOP, K_JUMP, K_BURST, K_SPARSE_BLT, K_SPARSE_REG, K_MEM, K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    ST_HDR, ST_BURST, ST_SPARSE, ST_PAD, ST_MADDR, ST_MDATA
  } state_e;

  typedef struct packed {
    logic [2:0]         ptype;
    logic [2:0]         code;
    logic [BCNT_W-1:0]  bcnt;
    logic               binc;
    logic [REG_AW-1:0]  sreg;
    logic [SMASK_W-1:0] smask;
    logic [XMASK_W-1:0] xmask;
    logic [PAD_W-1:0]   pad;
    logic [MCNT_W-1:0]  mcnt;
    logic [1:0]         dest;
    logic [BD_W-1:0]    bdis;
    logic [JUMP_W-1:0]  jump;
  } hdr_t;
endpackage

// File: rtl/cpd_hdr_decode.sv
module cpd_hdr_decode
  import cpd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              f,
  output kind_e             kind
);
  always_comb begin
    f.ptype = word[2:0];
    f.code  = word[5:3];
    f.bcnt  = word[31:16];
    f.binc  = word[15];
    f.sreg  = word[14:3];
    f.smask = word[31:3];
    f.xmask = word[28:15];
    f.pad   = word[31:29];
    f.mcnt  = word[21:3];
    f.dest  = word[31:30];
    f.bdis  = word[29:22];
    f.jump  = {word[27:6], 2'b00};
  end

  always_comb begin
    unique case (f.ptype)
      3'd0: begin
        if (f.code == 3'd0)      kind = K_NOP;
        else if (f.code == 3'd3) kind = K_JUMP;
        else                     kind = K_BAD;
      end
      3'd1: kind = K_BURST;
      3'd2: kind = K_SPARSE_BLT;
      3'd4: kind = K_SPARSE_REG;
      3'd5: kind = f.dest[1] ? K_MEM : K_BAD;
      default: kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/cpd_low_bit.sv
module cpd_low_bit #(
  parameter int W  = 29,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [W:0]   below_clear;
  logic [W-1:0] first;

  assign below_clear[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign first[i]         = mask[i] & below_clear[i];
    assign below_clear[i+1] = below_clear[i] & ~mask[i];
  end

  assign any = ~below_clear[W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/cpd_out_slot.sv
module cpd_out_slot #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         can_load,
  output logic         valid,
  output logic [W-1:0] dout
);
  assign can_load = ~valid | ready;

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

  // R10: a stalled transaction keeps its payload
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R10: the decoder never loads over a transaction that has not left
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> can_load);
endmodule

// File: rtl/cmd_packet_decoder.sv
module cmd_packet_decoder
  import cpd_pkg::*;
#(
  parameter logic [11:0] SPARSE_BASE = 12'h0B0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_data,
  output logic                 in_ready,
  output logic                 reg_wr_valid,
  input  logic                 reg_wr_ready,
  output logic [REG_AW-1:0]    reg_wr_addr,
  output logic [WORD_W-1:0]    reg_wr_data,
  output logic                 mem_wr_valid,
  input  logic                 mem_wr_ready,
  output logic                 mem_wr_tex,
  output logic [MEM_AW-1:0]    mem_wr_addr,
  output logic [WORD_W-1:0]    mem_wr_data,
  output logic                 jump_valid,
  output logic [JUMP_W-1:0]    jump_addr,
  output logic                 err_unsup,
  output logic                 warn_bytedis
);
  localparam int RSLOT_W = REG_AW + WORD_W;
  localparam int MSLOT_W = 1 + MEM_AW + WORD_W;

  state_e              state;
  logic [MCNT_W-1:0]   cnt;
  logic [REG_AW-1:0]   cur_reg;
  logic                incr;
  logic [SMASK_W-1:0]  smask;
  logic [REG_AW-1:0]   base;
  logic [PAD_W-1:0]    pad;
  logic                mdest;
  logic [MEM_AW-1:0]   maddr;

  hdr_t                hf;
  kind_e               kind;
  logic                s_any;
  logic [SIDX_W-1:0]   s_idx;
  logic                reg_can, mem_can;
  logic                in_fire, reg_load, mem_load;
  logic [REG_AW-1:0]   wr_reg;
  logic [SMASK_W-1:0]  smask_next;
  logic [RSLOT_W-1:0]  rslot_q;
  logic [MSLOT_W-1:0]  mslot_q;

  cpd_hdr_decode u_hdr (
    .word (in_data),
    .f    (hf),
    .kind (kind)
  );

  cpd_low_bit #(.W(SMASK_W)) u_low (
    .mask (smask),
    .any  (s_any),
    .idx  (s_idx)
  );

  always_comb begin
    unique case (state)
      ST_BURST, ST_SPARSE: in_ready = reg_can;
      ST_MDATA:            in_ready = mem_can;
      default:             in_ready = 1'b1;
    endcase
  end

  assign in_fire    = in_valid & in_ready;
  assign reg_load   = in_fire & ((state == ST_BURST) | (state == ST_SPARSE & s_any));
  assign mem_load   = in_fire & (state == ST_MDATA);
  assign wr_reg     = (state == ST_BURST) ? cur_reg : base + REG_AW'(s_idx);
  assign smask_next = smask & (smask - SMASK_W'(1));

  cpd_out_slot #(.W(RSLOT_W)) u_rslot (
    .clk      (clk),
    .rst      (rst),
    .load     (reg_load),
    .din      ({wr_reg, in_data}),
    .ready    (reg_wr_ready),
    .can_load (reg_can),
    .valid    (reg_wr_valid),
    .dout     (rslot_q)
  );

  cpd_out_slot #(.W(MSLOT_W)) u_mslot (
    .clk      (clk),
    .rst      (rst),
    .load     (mem_load),
    .din      ({mdest, maddr, in_data}),
    .ready    (mem_wr_ready),
    .can_load (mem_can),
    .valid    (mem_wr_valid),
    .dout     (mslot_q)
  );

  assign {reg_wr_addr, reg_wr_data}             = rslot_q;
  assign {mem_wr_tex, mem_wr_addr, mem_wr_data} = mslot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_HDR;
      cnt          <= '0;
      cur_reg      <= '0;
      incr         <= 1'b0;
      smask        <= '0;
      base         <= '0;
      pad          <= '0;
      mdest        <= 1'b0;
      maddr        <= '0;
      jump_valid   <= 1'b0;
      jump_addr    <= '0;
      err_unsup    <= 1'b0;
      warn_bytedis <= 1'b0;
    end else begin
      jump_valid   <= 1'b0;
      err_unsup    <= 1'b0;
      warn_bytedis <= 1'b0;
      if (in_fire) begin
        unique case (state)
          ST_HDR: begin
            unique case (kind)
              K_JUMP: begin
                jump_valid <= 1'b1;
                jump_addr  <= hf.jump;
              end
              K_BURST: begin
                cnt     <= MCNT_W'(hf.bcnt);
                cur_reg <= hf.sreg;
                incr    <= hf.binc;
                if (hf.bcnt != '0) state <= ST_BURST;
              end
              K_SPARSE_BLT: begin
                smask <= hf.smask;
                base  <= SPARSE_BASE;
                pad   <= '0;
                if (hf.smask != '0) state <= ST_SPARSE;
              end
              K_SPARSE_REG: begin
                smask <= SMASK_W'(hf.xmask);
                base  <= hf.sreg;
                pad   <= hf.pad;
                if (hf.xmask != '0)    state <= ST_SPARSE;
                else if (hf.pad != '0) state <= ST_PAD;
              end
              K_MEM: begin
                cnt          <= hf.mcnt;
                mdest        <= hf.dest[0];
                warn_bytedis <= (hf.bdis != '0);
                state        <= ST_MADDR;
              end
              K_BAD:   err_unsup <= 1'b1;
              default: ;
            endcase
          end
          ST_BURST: begin
            cnt <= cnt - MCNT_W'(1);
            if (incr) cur_reg <= cur_reg + REG_AW'(1);
            if (cnt == MCNT_W'(1)) state <= ST_HDR;
          end
          ST_SPARSE: begin
            smask <= smask_next;
            if (smask_next == '0) state <= (pad != '0) ? ST_PAD : ST_HDR;
          end
          ST_PAD: begin
            pad <= pad - PAD_W'(1);
            if (pad == PAD_W'(1)) state <= ST_HDR;
          end
          ST_MADDR: begin
            maddr <= in_data[23:2];
            state <= (cnt == '0) ? ST_HDR : ST_MDATA;
          end
          ST_MDATA: begin
            cnt   <= cnt - MCNT_W'(1);
            maddr <= maddr + MEM_AW'(1);
            if (cnt == MCNT_W'(1)) state <= ST_HDR;
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  // R11: clean outputs right after reset
  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!reg_wr_valid && !mem_wr_valid && !jump_valid && !err_unsup && in_ready));

  // R3: each accepted burst word becomes a pending register write
  a_r3_burst_emits: assert property (@(posedge clk) disable iff (rst)
    (in_fire && state == ST_BURST) |=> reg_wr_valid);

  // R7: each accepted memory data word becomes a pending memory write
  a_r7_mem_emits: assert property (@(posedge clk) disable iff (rst)
    (in_fire && state == ST_MDATA) |=> mem_wr_valid);

  // R9: an unsupported header leaves the decoder waiting for a header
  a_r9_err_to_hdr: assert property (@(posedge clk) disable iff (rst)
    err_unsup |-> (state == ST_HDR));

  // R2: a jump consumes no data words
  a_r2_jump_to_hdr: assert property (@(posedge clk) disable iff (rst)
    jump_valid |-> (state == ST_HDR));

  // R6: pad words produce no register write
  a_r6_pad_silent: assert property (@(posedge clk) disable iff (rst)
    (in_fire && state == ST_PAD && !reg_wr_valid) |=> !reg_wr_valid);
endmodule

// File: tb/cmd_packet_decoder_test.sv
module cmd_packet_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] BLT_BASE = 12'h0B0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        reg_wr_valid, mem_wr_valid, mem_wr_tex;
  logic [11:0] reg_wr_addr;
  logic [31:0] reg_wr_data, mem_wr_data;
  logic [21:0] mem_wr_addr;
  logic        jump_valid, err_unsup, warn_bytedis;
  logic [23:0] jump_addr;
  logic        sink_rdy = 1'b1;
  logic        bp = 1'b0;
  int          cyc = 0;

  int total = 0, bad = 0;
  int reg_n, mem_n, jmp_n, err_n, warn_n, stall_n;
  logic [11:0] reg_a [0:63];
  logic [31:0] reg_d [0:63];
  logic [21:0] mem_a [0:63];
  logic [31:0] mem_d [0:63];
  logic        mem_t [0:63];
  logic [23:0] jmp_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_packet_decoder #(.SPARSE_BASE(BLT_BASE)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(sink_rdy), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(sink_rdy),
    .mem_wr_tex(mem_wr_tex), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .jump_valid(jump_valid), .jump_addr(jump_addr), .err_unsup(err_unsup),
    .warn_bytedis(warn_bytedis)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sink_rdy <= bp ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (reg_wr_valid && sink_rdy) begin
      if (reg_n < 64) begin reg_a[reg_n] = reg_wr_addr; reg_d[reg_n] = reg_wr_data; end
      reg_n++;
    end
    if (mem_wr_valid && sink_rdy) begin
      if (mem_n < 64) begin
        mem_a[mem_n] = mem_wr_addr; mem_d[mem_n] = mem_wr_data; mem_t[mem_n] = mem_wr_tex;
      end
      mem_n++;
    end
    if (jump_valid) begin jmp_n++; jmp_last = jump_addr; end
    if (err_unsup) err_n++;
    if (warn_bytedis) warn_n++;
    if (in_valid && !in_ready) stall_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    reg_n = 0; mem_n = 0; jmp_n = 0; err_n = 0; warn_n = 0; stall_n = 0;
  endtask

  task automatic send(input logic [31:0] w);
    in_data  = w;
    in_valid = 1'b1;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  function automatic logic [31:0] jhdr(input logic [23:0] t);
    return ({8'h0, t} << 4) | 32'h18;
  endfunction

  task automatic t_reset();
    chk("R11 in_ready", in_ready, 1);
    chk("R11 reg valid", reg_wr_valid, 0);
    chk("R11 mem valid", mem_wr_valid, 0);
    chk("R11 pulses", {jump_valid, err_unsup, warn_bytedis}, 0);
  endtask

  task automatic t_nop();
    clear_logs();
    send(32'h0000_0000);
    send(jhdr(24'h000100));
    drain();
    chk("R1 nop no write", reg_n + mem_n, 0);
    chk("R1 nop no error", err_n, 0);
    chk("R1 nop then header", jmp_n, 1);
  endtask

  task automatic t_jump();
    clear_logs();
    send(32'hF000_0000 | jhdr(24'hAB_CDE4));
    chk("R2 jump pulse", jump_valid, 1);
    chk("R2 jump addr", jump_addr, 24'hAB_CDE4);
    @(negedge clk);
    chk("R2 jump one cycle", jump_valid, 0);
  endtask

  task automatic t_burst(input logic inc, input logic [11:0] start, input int n);
    clear_logs();
    send({16'(n), inc, start, 3'd1});
    for (int i = 0; i < n; i++) send(32'hD000_0000 + i);
    drain();
    chk("R3 burst count", reg_n, n);
    for (int i = 0; i < n; i++) begin
      chk("R3 burst addr", reg_a[i], inc ? start + 12'(i) : start);
      chk("R3 burst data", reg_d[i], 32'hD000_0000 + i);
    end
  endtask

  task automatic t_burst_zero();
    clear_logs();
    send({16'd0, 1'b1, 12'h040, 3'd1});
    send(jhdr(24'h000200));
    drain();
    chk("R4 zero count no write", reg_n, 0);
    chk("R4 next word is header", jmp_n, 1);
    chk("R4 jump target", jmp_last, 24'h000200);
  endtask

  task automatic t_sparse_blt();
    logic [28:0] m = 29'h1000020B;
    int k = 0;
    clear_logs();
    send({m, 3'd2});
    for (int i = 0; i < 29; i++) if (m[i]) send(32'h5500_0000 + i);
    drain();
    chk("R5 word count", reg_n, 5);
    for (int i = 0; i < 29; i++) begin
      if (m[i]) begin
        chk("R5 addr", reg_a[k], BLT_BASE + 12'(i));
        chk("R5 data", reg_d[k], 32'h5500_0000 + i);
        k++;
      end
    end
  endtask

  task automatic t_sparse_reg(input logic [13:0] m, input logic [2:0] p);
    int k = 0;
    int ones = 0;
    clear_logs();
    send({p, m, 12'h300, 3'd4});
    for (int i = 0; i < 14; i++) if (m[i]) begin send(32'h6600_0000 + i); ones++; end
    for (int i = 0; i < int'(p); i++) send(32'hDEAD_0000 + i);
    send(jhdr(24'h000300));
    drain();
    chk("R6 masked writes only", reg_n, ones);
    for (int i = 0; i < 14; i++) begin
      if (m[i]) begin
        chk("R6 addr", reg_a[k], 12'h300 + 12'(i));
        chk("R6 data", reg_d[k], 32'h6600_0000 + i);
        k++;
      end
    end
    chk("R6 header after pads", jmp_n, 1);
  endtask

  task automatic t_mem(input logic [1:0] d, input logic [7:0] bd, input int n,
                       input logic [31:0] aw);
    logic [21:0] a0 = aw[23:2];
    clear_logs();
    send({d, bd, 19'(n), 3'd5});
    chk("R8 warn pulse", warn_bytedis, (bd != 0));
    send(aw);
    for (int i = 0; i < n; i++) send(32'h7700_0000 + i);
    send(jhdr(24'h000400));
    drain();
    chk("R7 mem count", mem_n, n);
    chk("R7 no reg write", reg_n, 0);
    for (int i = 0; i < n; i++) begin
      chk("R7 mem addr", mem_a[i], a0 + 22'(i));
      chk("R7 mem data", mem_d[i], 32'h7700_0000 + i);
      chk("R7 mem dest", mem_t[i], d[0]);
    end
    chk("R8 warn count", warn_n, (bd != 0) ? 1 : 0);
    chk("R7 header after data", jmp_n, 1);
  endtask

  task automatic t_unsup(input logic [31:0] h);
    clear_logs();
    send(h);
    chk("R9 err pulse", err_unsup, 1);
    send(jhdr(24'h000500));
    drain();
    chk("R9 err count", err_n, 1);
    chk("R9 next word is header", jmp_n, 1);
    chk("R9 no write", reg_n + mem_n, 0);
  endtask

  task automatic t_backpressure();
    clear_logs();
    bp = 1'b1;
    send({16'd6, 1'b1, 12'h010, 3'd1});
    for (int i = 0; i < 6; i++) send(32'hB000_0000 + i);
    send({2'd3, 8'd0, 19'd3, 3'd5});
    send(32'h0000_0100);
    for (int i = 0; i < 3; i++) send(32'hC000_0000 + i);
    drain();
    bp = 1'b0;
    chk("R10 stalls seen", (stall_n > 0), 1);
    chk("R10 reg count", reg_n, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R10 reg addr", reg_a[i], 12'h010 + 12'(i));
      chk("R10 reg data", reg_d[i], 32'hB000_0000 + i);
    end
    chk("R10 mem count", mem_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R10 mem addr", mem_a[i], 22'h40 + 22'(i));
      chk("R10 mem data", mem_d[i], 32'hC000_0000 + i);
    end
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nop();
    t_jump();
    t_burst(1'b1, 12'h120, 4);
    t_burst(1'b0, 12'h2A0, 3);
    t_burst_zero();
    t_sparse_blt();
    t_sparse_reg(14'b10_0000_0010_0100, 3'd3);
    t_sparse_reg(14'd0, 3'd2);
    t_mem(2'd2, 8'h00, 3, 32'hFF00_1234);
    t_mem(2'd3, 8'h81, 2, 32'h0000_0040);
    t_mem(2'd2, 8'h00, 0, 32'h0000_0080);
    t_unsup(32'h0000_0003);
    t_unsup(32'h0000_0006);
    t_unsup(32'h0000_0007);
    t_unsup(32'h0000_0028);
    t_unsup({2'd1, 8'd0, 19'd4, 3'd5});
    t_backpressure();
  endtask

  initial begin
    clear_logs();
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule